// File: doc/BRIEF.md
# Link Bring-Up and Speed Negotiation Sequencer

This block drives the start-up of a serial link on behalf of the link training logic. On a start pulse it forces the advertised speed ceiling to generation 1 and enables training. It then waits, with a bounded timeout, until the link reports up with training finished. Once the link is up it optionally lifts the ceiling to generation 2 and raises a directed speed change request. It polls at a fixed interval until the training logic drops its busy indication, and then waits for a settled link a second time before it reports success together with the negotiated generation.

Every failure path (first link wait, speed change poll, second link wait) ends the same way. Two receive override controls, for receive data and receive PLL, are held high for a programmed number of cycles and then released, after which the error output is raised. Success or error is held until the next start. While a sequence is running the start input has no effect.

Top module: `link_speed_seq`

## Requirements
- R1: After reset, max_speed is 1, neg_gen is 0, and train_en, spd_req, ovr_word, done and error are all low.
- R2: A start pulse accepted while the block is idle or finished sets max_speed to 1 and train_en high, and clears done, error and neg_gen, all visible after the edge that samples start.
- R3: The link counts as up only when link_up is 1 and in_training is 0 on the same edge. If no such edge occurs within LINK_TO edges of waiting, the block takes the failure path.
- R4: On the edge that sees the first valid link, max_speed becomes 2 if cfg_max_gen equals 2 and stays 1 for any other value, and spd_req rises.
- R5: With spd_req high, spd_busy is sampled every POLL_GAP edges. The first poll that sees it low drops spd_req. If the POLL_TRIES-th poll still sees it high, the block takes the failure path.
- R6: After spd_req drops, a second bounded wait for a valid link (same rule as R3) follows. On success done rises and neg_gen takes the value of neg_gen_in on that edge.
- R7: On entering the failure path, train_en and spd_req drop and ovr_word bits 5 (receive data override) and 3 (receive PLL override) go high with all other bits 0, for exactly RST_HOLD cycles. ovr_word then returns to 0 and error rises on the same edge.
- R8: A start pulse while a sequence is in progress is ignored and does not disturb its timing.
- R9: done, error, neg_gen and max_speed hold their values after completion until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up sequence |
| link_up | input | 1 | Link reports up |
| in_training | input | 1 | Link is still training |
| spd_busy | input | 1 | Directed speed change still in progress |
| cfg_max_gen | input | 4 | Highest generation allowed (2 enables the upgrade) |
| neg_gen_in | input | 4 | Current negotiated generation from link status |
| max_speed | output | 4 | Advertised maximum speed field |
| train_en | output | 1 | Training enable |
| spd_req | output | 1 | Directed speed change request |
| ovr_word | output | 16 | PHY receive override word (bit 5 data, bit 3 PLL) |
| done | output | 1 | Sequence succeeded |
| error | output | 1 | Sequence failed |
| neg_gen | output | 4 | Generation captured at success |

## Verification
A wrong state or a miscounted timer shows at the ports within one cycle: spd_req rising or falling an edge early or late, the override pulse being one cycle too long or too short, or done or error arriving at the wrong edge. Every output is therefore compared on every cycle of each sequence against a timeline derived arithmetically from the link delay, the busy duration and the parameters. A poll counter that is off by one moves the failure edge by a full poll interval, and a start that leaks through while busy shifts all later edges, so both show up at once.

// File: rtl/link_speed_seq.sv
module link_speed_seq #(
  parameter int LINK_TO    = 1000000,
  parameter int POLL_GAP   = 25000,
  parameter int POLL_TRIES = 200,
  parameter int RST_HOLD   = 625000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        link_up,
  input  logic        in_training,
  input  logic        spd_busy,
  input  logic [3:0]  cfg_max_gen,
  input  logic [3:0]  neg_gen_in,
  output logic [3:0]  max_speed,
  output logic        train_en,
  output logic        spd_req,
  output logic [15:0] ovr_word,
  output logic        done,
  output logic        error,
  output logic [3:0]  neg_gen
);

  localparam int TMAX = (LINK_TO > POLL_GAP) ? ((LINK_TO > RST_HOLD) ? LINK_TO : RST_HOLD)
                                             : ((POLL_GAP > RST_HOLD) ? POLL_GAP : RST_HOLD);
  localparam int TW = $clog2(TMAX + 1);
  localparam int NW = $clog2(POLL_TRIES + 1);
  localparam logic [TW-1:0] LINK_LAST = TW'(LINK_TO - 1);
  localparam logic [TW-1:0] GAP_LAST  = TW'(POLL_GAP - 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(RST_HOLD - 1);
  localparam logic [NW-1:0] TRY_LAST  = NW'(POLL_TRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT1, S_POLL, S_WAIT2, S_PHYRST, S_DONE, S_ERR} st_t;

  st_t           state;
  logic [TW-1:0] timer;
  logic [NW-1:0] tries;
  logic          ovr_on;

  wire link_ok  = link_up & ~in_training;
  wire can_start = (state == S_IDLE) | (state == S_DONE) | (state == S_ERR);

  assign ovr_word = {10'b0, ovr_on, 1'b0, ovr_on, 3'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      timer     <= '0;
      tries     <= '0;
      ovr_on    <= 1'b0;
      max_speed <= 4'd1;
      train_en  <= 1'b0;
      spd_req   <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      neg_gen   <= 4'd0;
    end else if (can_start) begin
      if (start) begin
        state     <= S_WAIT1;
        timer     <= '0;
        max_speed <= 4'd1;
        train_en  <= 1'b1;
        spd_req   <= 1'b0;
        done      <= 1'b0;
        error     <= 1'b0;
        neg_gen   <= 4'd0;
      end
    end else begin
      case (state)
        S_WAIT1: begin
          if (link_ok) begin
            state     <= S_POLL;
            max_speed <= (cfg_max_gen == 4'd2) ? 4'd2 : 4'd1;
            spd_req   <= 1'b1;
            timer     <= '0;
            tries     <= '0;
          end else if (timer == LINK_LAST) begin
            state    <= S_PHYRST;
            train_en <= 1'b0;
            spd_req  <= 1'b0;
            ovr_on   <= 1'b1;
            timer    <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_POLL: begin
          if (timer == GAP_LAST) begin
            timer <= '0;
            if (!spd_busy) begin
              state   <= S_WAIT2;
              spd_req <= 1'b0;
            end else if (tries == TRY_LAST) begin
              state    <= S_PHYRST;
              train_en <= 1'b0;
              spd_req  <= 1'b0;
              ovr_on   <= 1'b1;
            end else begin
              tries <= tries + 1'b1;
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_WAIT2: begin
          if (link_ok) begin
            state   <= S_DONE;
            done    <= 1'b1;
            neg_gen <= neg_gen_in;
          end else if (timer == LINK_LAST) begin
            state    <= S_PHYRST;
            train_en <= 1'b0;
            ovr_on   <= 1'b1;
            timer    <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_PHYRST: begin
          if (timer == HOLD_LAST) begin
            state  <= S_ERR;
            ovr_on <= 1'b0;
            error  <= 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module link_speed_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        in_training,
  input logic        spd_busy,
  input logic [3:0]  max_speed,
  input logic        spd_req,
  input logic [15:0] ovr_word,
  input logic        done,
  input logic        error
);

  // R3
  done_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(link_up && !in_training));

  // R4
  speed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (max_speed == 4'd1) || (max_speed == 4'd2));

  // R5
  req_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spd_req) && ovr_word == 16'h0) |-> !$past(spd_busy));

  // R7
  ovr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_word == 16'h0) || (ovr_word == 16'h0028));

  // R7
  err_after_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> ($past(ovr_word) == 16'h0028 && ovr_word == 16'h0));

  // R7
  no_req_in_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_word != 16'h0) |-> !spd_req);

  // R9
  excl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

endmodule

bind link_speed_seq link_speed_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .in_training(in_training),
  .spd_busy(spd_busy), .max_speed(max_speed), .spd_req(spd_req),
  .ovr_word(ovr_word), .done(done), .error(error)
);

// File: tb/link_speed_seq_tb_top.sv
`timescale 1ns/1ps
module link_speed_seq_tb_top;

  localparam int LT   = 8;
  localparam int GAP  = 4;
  localparam int TRY  = 5;
  localparam int HOLD = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        link_up = 1'b0;
  logic        in_training = 1'b0;
  logic        spd_busy = 1'b0;
  logic [3:0]  cfg_max_gen = 4'd1;
  logic [3:0]  neg_gen_in = 4'd0;
  logic [3:0]  max_speed;
  logic        train_en;
  logic        spd_req;
  logic [15:0] ovr_word;
  logic        done;
  logic        error;
  logic [3:0]  neg_gen;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  link_speed_seq #(.LINK_TO(LT), .POLL_GAP(GAP), .POLL_TRIES(TRY), .RST_HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up), .in_training(in_training),
    .spd_busy(spd_busy), .cfg_max_gen(cfg_max_gen), .neg_gen_in(neg_gen_in),
    .max_speed(max_speed), .train_en(train_en), .spd_req(spd_req), .ovr_word(ovr_word),
    .done(done), .error(error), .neg_gen(neg_gen)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp = n_cmp + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int l1, input int b, input int l2, input int cfg, input bit poke);
    int e1, e2, er, es, endt, gen;
    bit tease;
    e1 = -1; e2 = -1; er = -1; es = -1;
    gen = (l1 + b + l2 + cfg) & 15;
    tease = ((l1 + l2) % 2) == 1;
    if (l1 > LT) er = LT;
    else begin
      int k;
      e1 = l1;
      k = b / GAP + 1;
      if (k > TRY) er = e1 + GAP * TRY;
      else begin
        e2 = e1 + GAP * k;
        if (l2 <= LT) es = e2 + l2;
        else er = e2 + LT;
      end
    end
    endt = (es >= 0) ? es : er + HOLD;

    @(negedge clk);
    start = 1'b1; link_up = 1'b0; in_training = 1'b0; spd_busy = 1'b0;
    cfg_max_gen = 4'(cfg); neg_gen_in = 4'(gen);
    for (int e = 0; e <= endt + 3; e++) begin
      int x;
      bit te, sr, ov, eo, dn;
      int ms;
      @(posedge clk);
      @(negedge clk);
      te = (er < 0) || (e < er);
      sr = (e1 >= 0) && (e >= e1) && ((e2 >= 0) ? (e < e2) : (e < er));
      ms = ((e1 >= 0) && (e >= e1) && cfg == 2) ? 2 : 1;
      ov = (er >= 0) && (e >= er) && (e < er + HOLD);
      eo = (er >= 0) && (e >= er + HOLD);
      dn = (es >= 0) && (e >= es);
      chk("R2/R7 train_en", int'(train_en), int'(te));
      chk("R4/R5 spd_req", int'(spd_req), int'(sr));
      chk("R2/R4 max_speed", int'(max_speed), ms);
      chk("R7 ovr_word", int'(ovr_word), ov ? 40 : 0);
      chk("R7/R9 error", int'(error), int'(eo));
      chk("R3/R6 done", int'(done), int'(dn));
      chk("R6/R9 neg_gen", int'(neg_gen), dn ? gen : 0);
      // next edge inputs; R8 poke keeps timing unchanged
      x = e + 1;
      start = (poke && x == 2) ? 1'b1 : 1'b0;
      spd_busy = (e1 >= 0) && (x <= e1 + b);
      if (e2 < 0 || x <= e2) begin
        link_up = tease || (x >= l1);
        in_training = (x < l1);
      end else begin
        link_up = tease || (x >= e2 + l2);
        in_training = (x < e2 + l2);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    int bset [6] = '{0, 3, 4, 7, 19, 20};
    int l2set [4] = '{1, 4, 8, 9};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 max_speed", int'(max_speed), 1);
    chk("R1 train_en", int'(train_en), 0);
    chk("R1 spd_req", int'(spd_req), 0);
    chk("R1 ovr_word", int'(ovr_word), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 error", int'(error), 0);
    chk("R1 neg_gen", int'(neg_gen), 0);
    for (int l1 = 1; l1 <= LT + 1; l1++)
      for (int bi = 0; bi < 6; bi++)
        for (int li = 0; li < 4; li++)
          for (int cfg = 1; cfg <= 3; cfg++)
            run(l1, bset[bi], l2set[li], cfg, cfg == 3);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule